// File: doc/BRIEF.md
# Tagged Software-Refilled Translation Buffer

This block is a small, fully associative cache of address translations. It turns a virtual address into a physical address for the process that is currently running. Each entry holds several fields:

- a virtual tag and a physical base;
- a page size of 4 KB, 2 MB or 1 GB;
- a process identifier, with a global flag that makes the entry match any process;
- a write-permission bit.

A lookup that finds no entry does not walk any table. It raises a miss trap. System software then works out the mapping, writes it through the fill port and retries the access. A write to an entry that is not writable raises a separate permission trap, which gives software the hook it needs for copy-on-write.

When software changes a mapping, the purge port invalidates the entries that cover one virtual page for one process. The flush-all input empties the whole buffer in one cycle. A fill goes to the lowest-numbered free entry. If no entry is free, a round-robin pointer picks the victim.

Every lookup gets its answer one cycle after the request, from registered outputs.

Top module: `sw_tlb`

## Requirements
- R1: A lookup that matches an entry with a 4 KB page returns a hit. The physical address is the entry's physical base with its bits [11:0] replaced by the virtual address bits [11:0].
- R2: A lookup that matches no valid entry returns a miss trap, with no hit and with a physical address of zero.
- R3: A non-global entry matches only when its process ID equals `cur_pid_i`. An entry filled with the global flag set matches under any process ID.
- R4: The page-size code decides which low bits the compare ignores and which pass straight to the physical address. Code 0 is 4 KB (bits [11:0]), code 1 is 2 MB (bits [20:0]), code 2 is 1 GB (bits [29:0]), and code 3 behaves as 4 KB.
- R5: A write lookup that matches an entry filled with the writable bit clear returns a permission trap, with no hit and a physical address of zero. A read lookup to the same entry returns a hit.
- R6: A purge invalidates every entry that covers `purge_vaddr_i` and whose process ID equals `purge_pid_i` or which is global. Other entries stay valid.
- R7: When `flush_all_i` is high at a clock edge, every entry becomes invalid.
- R8: A fill writes the lowest-indexed invalid entry. When all entries are valid, it writes the entry at the round-robin pointer. The pointer starts at 0 and advances by one, wrapping, only on fills that find no invalid entry.
- R9: When several entries match a lookup, the lowest-indexed one supplies the result.
- R10: `resp_valid_o` is high exactly one cycle after `req_valid_i`, and exactly one of hit, miss trap and permission trap is high with it. The lookup sees the contents as they were before any fill, purge or flush in the same cycle.
- R11: After reset, all entries are invalid and all response outputs are low.
- R12: A fill in the same cycle as `flush_all_i` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cur_pid_i | input | PID_W | Process ID of the running process |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | VA_W | Lookup virtual address |
| req_write_i | input | 1 | Lookup is a write |
| resp_valid_o | output | 1 | Lookup result valid |
| resp_hit_o | output | 1 | Translation succeeded |
| resp_paddr_o | output | PA_W | Physical address (zero unless hit) |
| trap_miss_o | output | 1 | No matching entry |
| trap_perm_o | output | 1 | Write to a read-only mapping |
| fill_valid_i | input | 1 | Write one entry |
| fill_vaddr_i | input | VA_W | Virtual page of the new entry |
| fill_paddr_i | input | PA_W | Physical base of the new entry |
| fill_size_i | input | 2 | Page-size code (0 = 4 KB, 1 = 2 MB, 2 = 1 GB) |
| fill_pid_i | input | PID_W | Process ID tag of the new entry |
| fill_global_i | input | 1 | New entry matches any process |
| fill_write_i | input | 1 | New entry allows writes |
| purge_valid_i | input | 1 | Invalidate entries for one page |
| purge_vaddr_i | input | VA_W | Virtual address to purge |
| purge_pid_i | input | PID_W | Process ID to purge |
| flush_all_i | input | 1 | Invalidate all entries |

## Verification
Two pairs of operations can fall in the same cycle, and both are exercised.

- **Lookup with purge.** The bench raises a lookup and a purge of the same page on one clock edge. It expects a hit carrying the old translation, and then a miss on the next lookup.
- **Lookup with fill.** The bench raises a lookup and a fill of a missing page on one edge. It expects a miss, and then a hit on the retry.

A fill raised together with the flush-all input is judged by looking the filled page up afterwards, which must miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_1G  = 2'd2,
    PG_RSV = 2'd3
  } pg_size_e;

  localparam int unsigned OFF_MAX = 30;

  function automatic int unsigned pg_shift(pg_size_e s);
    case (s)
      PG_2M:   return 21;
      PG_1G:   return 30;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W  = 40,
  parameter int unsigned PID_W = 8
) (
  input  logic             valid_i,
  input  logic [VA_W-1:0]  etag_i,
  input  pg_size_e         size_i,
  input  logic [PID_W-1:0] epid_i,
  input  logic             glob_i,
  input  logic [VA_W-1:0]  qva_i,
  input  logic [PID_W-1:0] qpid_i,
  output logic             hit_o
);
  logic [VA_W-1:0] off_m;

  assign off_m = (VA_W'(1) << pg_shift(size_i)) - VA_W'(1);
  assign hit_o = valid_i
              && (((etag_i ^ qva_i) & ~off_m) == '0)
              && (glob_i || (epid_i == qpid_i));
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  valid_i,
  input  logic          fill_en_i,
  output logic [IW-1:0] victim_o
);
  logic          free_any;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] ptr_q;

  tlb_prio #(.N(N)) u_free (
    .req_i  (~valid_i),
    .found_o(free_any),
    .idx_o  (free_idx)
  );

  assign victim_o = free_any ? free_idx : ptr_q;

  // pointer moves only when it was actually used
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (fill_en_i && !free_any) begin
      ptr_q <= (ptr_q == IW'(N - 1)) ? '0 : ptr_q + IW'(1);
    end
  end

  p_victim_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && !(&valid_i)) |-> !valid_i[victim_o]);

  p_ptr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_en_i && (&valid_i)) |=> $stable(ptr_q));
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  parameter int unsigned VA_W  = 40,
  parameter int unsigned PA_W  = 40,
  parameter int unsigned PID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PID_W-1:0] cur_pid_i,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  output logic             resp_valid_o,
  output logic             resp_hit_o,
  output logic [PA_W-1:0]  resp_paddr_o,
  output logic             trap_miss_o,
  output logic             trap_perm_o,
  input  logic             fill_valid_i,
  input  logic [VA_W-1:0]  fill_vaddr_i,
  input  logic [PA_W-1:0]  fill_paddr_i,
  input  logic [1:0]       fill_size_i,
  input  logic [PID_W-1:0] fill_pid_i,
  input  logic             fill_global_i,
  input  logic             fill_write_i,
  input  logic             purge_valid_i,
  input  logic [VA_W-1:0]  purge_vaddr_i,
  input  logic [PID_W-1:0] purge_pid_i,
  input  logic             flush_all_i
);
  localparam int unsigned IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [VA_W-1:0]  vtag_q [N_ENT];
  logic [PA_W-1:0]  ptag_q [N_ENT];
  pg_size_e         size_q [N_ENT];
  logic [PID_W-1:0] pid_q  [N_ENT];
  logic [N_ENT-1:0] glob_q, wr_q, valid_q, valid_d;
  logic [N_ENT-1:0] lk_hit, pg_hit, fill_we;

  logic             lk_any;
  logic [IW-1:0]    lk_idx, vic_idx;
  logic             fill_en;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    tlb_match #(.VA_W(VA_W), .PID_W(PID_W)) u_lk (
      .valid_i(valid_q[g]), .etag_i(vtag_q[g]), .size_i(size_q[g]),
      .epid_i(pid_q[g]), .glob_i(glob_q[g]),
      .qva_i(req_vaddr_i), .qpid_i(cur_pid_i), .hit_o(lk_hit[g])
    );
    tlb_match #(.VA_W(VA_W), .PID_W(PID_W)) u_pg (
      .valid_i(valid_q[g]), .etag_i(vtag_q[g]), .size_i(size_q[g]),
      .epid_i(pid_q[g]), .glob_i(glob_q[g]),
      .qva_i(purge_vaddr_i), .qpid_i(purge_pid_i), .hit_o(pg_hit[g])
    );
  end

  tlb_prio #(.N(N_ENT)) u_prio (
    .req_i  (lk_hit),
    .found_o(lk_any),
    .idx_o  (lk_idx)
  );

  assign fill_en = fill_valid_i && !flush_all_i;

  tlb_victim #(.N(N_ENT)) u_vic (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_q),
    .fill_en_i(fill_en),
    .victim_o (vic_idx)
  );

  assign fill_we = fill_en ? (N_ENT'(1) << vic_idx) : '0;

  // flush beats everything; a fill beats a purge on its own slot
  always_comb begin
    if (flush_all_i) valid_d = '0;
    else valid_d = (valid_q & ~(purge_valid_i ? pg_hit : '0)) | fill_we;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      glob_q  <= '0;
      wr_q    <= '0;
      for (int i = 0; i < int'(N_ENT); i++) begin
        vtag_q[i] <= '0;
        ptag_q[i] <= '0;
        size_q[i] <= PG_4K;
        pid_q[i]  <= '0;
      end
    end else begin
      valid_q <= valid_d;
      for (int i = 0; i < int'(N_ENT); i++) begin
        if (fill_we[i]) begin
          vtag_q[i] <= fill_vaddr_i;
          ptag_q[i] <= fill_paddr_i;
          size_q[i] <= pg_size_e'(fill_size_i);
          pid_q[i]  <= fill_pid_i;
          glob_q[i] <= fill_global_i;
          wr_q[i]   <= fill_write_i;
        end
      end
    end
  end

  // lookup result
  pg_size_e        sel_size;
  logic [PA_W-1:0] sel_ptag, pa_m, va_low, pa_comb;
  logic            sel_wr, perm_bad;

  assign sel_size = size_q[lk_idx];
  assign sel_ptag = ptag_q[lk_idx];
  assign sel_wr   = wr_q[lk_idx];
  assign pa_m     = (PA_W'(1) << pg_shift(sel_size)) - PA_W'(1);
  assign va_low   = PA_W'(req_vaddr_i[OFF_MAX-1:0]);
  assign pa_comb  = (sel_ptag & ~pa_m) | (va_low & pa_m);
  assign perm_bad = lk_any && req_write_i && !sel_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      trap_miss_o  <= 1'b0;
      trap_perm_o  <= 1'b0;
      resp_paddr_o <= '0;
    end else begin
      resp_valid_o <= req_valid_i;
      resp_hit_o   <= req_valid_i && lk_any && !perm_bad;
      trap_miss_o  <= req_valid_i && !lk_any;
      trap_perm_o  <= req_valid_i && perm_bad;
      resp_paddr_o <= (req_valid_i && lk_any && !perm_bad) ? pa_comb : '0;
    end
  end

  p_resp_follows_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);

  p_no_resp_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o);

  p_one_outcome_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $onehot({resp_hit_o, trap_miss_o, trap_perm_o}));

  p_miss_zero_pa_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_hit_o |-> (resp_paddr_o == '0));

  p_flush_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (valid_q == '0));

  p_purge_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (purge_valid_i && !flush_all_i) |=> ((valid_q & $past(pg_hit & ~fill_we)) == '0));

  p_fill_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en |=> ($countones(valid_q & $past(fill_we)) == 1));

  p_fill_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fill_we));

  p_lowest_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_any |-> (lk_hit[lk_idx] && ((lk_hit & ((N_ENT'(1) << lk_idx) - N_ENT'(1))) == '0)));
endmodule

// File: tb/tb_sw_tlb.sv
module tb_sw_tlb;
  localparam int unsigned VA_W = 40, PA_W = 40, PID_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [PID_W-1:0] cur_pid = 8'd1;
  logic             req_valid = 0, req_write = 0;
  logic [VA_W-1:0]  req_vaddr = '0;
  logic             resp_valid, resp_hit, trap_miss, trap_perm;
  logic [PA_W-1:0]  resp_paddr;
  logic             fill_valid = 0, fill_global = 0, fill_write = 0;
  logic [VA_W-1:0]  fill_vaddr = '0;
  logic [PA_W-1:0]  fill_paddr = '0;
  logic [1:0]       fill_size = '0;
  logic [PID_W-1:0] fill_pid = '0;
  logic             purge_valid = 0, flush_all = 0;
  logic [VA_W-1:0]  purge_vaddr = '0;
  logic [PID_W-1:0] purge_pid = '0;

  int n_chk = 0, n_bad = 0;

  sw_tlb dut (
    .clk_i(clk), .rst_ni(rst_n), .cur_pid_i(cur_pid),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .resp_valid_o(resp_valid), .resp_hit_o(resp_hit), .resp_paddr_o(resp_paddr),
    .trap_miss_o(trap_miss), .trap_perm_o(trap_perm),
    .fill_valid_i(fill_valid), .fill_vaddr_i(fill_vaddr), .fill_paddr_i(fill_paddr),
    .fill_size_i(fill_size), .fill_pid_i(fill_pid), .fill_global_i(fill_global),
    .fill_write_i(fill_write),
    .purge_valid_i(purge_valid), .purge_vaddr_i(purge_vaddr), .purge_pid_i(purge_pid),
    .flush_all_i(flush_all)
  );

  function automatic logic [39:0] xl(input logic [39:0] base, va, input int sh);
    logic [39:0] m;
    m = (40'd1 << sh) - 40'd1;
    return (base & ~m) | (va & m);
  endfunction

  task automatic cmp(input string rq, input logic [63:0] got, exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  task automatic drive_fill(input logic [39:0] va, pa, input logic [1:0] sz,
                            input logic [7:0] pid, input logic gl, wr);
    fill_valid = 1; fill_vaddr = va; fill_paddr = pa; fill_size = sz;
    fill_pid = pid; fill_global = gl; fill_write = wr;
  endtask

  task automatic do_fill(input logic [39:0] va, pa, input logic [1:0] sz,
                         input logic [7:0] pid, input logic gl, wr);
    @(negedge clk); drive_fill(va, pa, sz, pid, gl, wr);
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic do_purge(input logic [39:0] va, input logic [7:0] pid);
    @(negedge clk); purge_valid = 1; purge_vaddr = va; purge_pid = pid;
    @(negedge clk); purge_valid = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush_all = 1;
    @(negedge clk); flush_all = 0;
  endtask

  // kind: 0 hit, 1 miss, 2 permission trap
  task automatic judge(input string rq, input int kind, input logic [39:0] epa);
    cmp(rq, {60'd0, resp_valid, resp_hit, trap_miss, trap_perm},
            {60'd0, 1'b1, kind == 0, kind == 1, kind == 2});
    cmp(rq, {24'd0, resp_paddr}, {24'd0, (kind == 0) ? epa : 40'd0});
  endtask

  task automatic check_lk(input string rq, input logic [39:0] va, input logic wr,
                          input int kind, input logic [39:0] epa);
    @(negedge clk); req_valid = 1; req_vaddr = va; req_write = wr;
    @(negedge clk); req_valid = 0; req_write = 0;
    judge(rq, kind, epa);
  endtask

  task automatic t_reset();
    cmp("R11 outputs", {59'd0, resp_valid, resp_hit, trap_miss, trap_perm, |resp_paddr}, 64'd0);
    check_lk("R11 empty", 40'h00_0000_1234, 0, 1, 0);
    @(negedge clk);
    cmp("R10 idle", {63'd0, resp_valid}, 64'd0);
  endtask

  task automatic t_basic();
    do_fill(40'h00_0012_3000, 40'h00_00AB_C000, 2'd0, 8'd1, 0, 1);
    check_lk("R1 hit", 40'h00_0012_3456, 0, 0, 40'h00_00AB_C456);
    check_lk("R2 miss", 40'h00_0012_4456, 0, 1, 0);
  endtask

  task automatic t_pid();
    do_fill(40'h00_0020_0000, 40'h00_0055_5000, 2'd0, 8'd3, 0, 1);
    do_fill(40'h00_0021_0000, 40'h00_0066_6000, 2'd0, 8'd3, 1, 1);
    cur_pid = 8'd3;
    check_lk("R3 same pid", 40'h00_0020_0010, 0, 0, 40'h00_0055_5010);
    cur_pid = 8'd4;
    check_lk("R3 other pid", 40'h00_0020_0010, 0, 1, 0);
    check_lk("R3 global", 40'h00_0021_0020, 0, 0, 40'h00_0066_6020);
    cur_pid = 8'd1;
  endtask

  task automatic t_super();
    do_fill(40'h12_3460_0000, 40'h0A_0000_0000, 2'd1, 8'd1, 0, 1);
    check_lk("R4 2M hit", 40'h12_3475_4321, 0, 0, xl(40'h0A_0000_0000, 40'h12_3475_4321, 21));
    check_lk("R4 2M next", 40'h12_3480_0000, 0, 1, 0);
    do_fill(40'h40_4000_0000, 40'h80_C000_0000, 2'd2, 8'd1, 0, 1);
    check_lk("R4 1G hit", 40'h40_7ABC_DEF0, 0, 0, 40'h80_FABC_DEF0);
    check_lk("R4 1G next", 40'h40_8000_0000, 0, 1, 0);
    do_fill(40'h00_0033_0000, 40'h00_0044_4000, 2'd3, 8'd1, 0, 1);
    check_lk("R4 code3 4K", 40'h00_0033_0ABC, 0, 0, 40'h00_0044_4ABC);
    check_lk("R4 code3 nbr", 40'h00_0033_1ABC, 0, 1, 0);
  endtask

  task automatic t_perm();
    do_fill(40'h00_0040_0000, 40'h00_0077_0000, 2'd0, 8'd1, 0, 0);
    check_lk("R5 ro read", 40'h00_0040_0008, 0, 0, 40'h00_0077_0008);
    check_lk("R5 ro write", 40'h00_0040_0008, 1, 2, 0);
    do_fill(40'h00_0040_1000, 40'h00_0078_0000, 2'd0, 8'd1, 0, 1);
    check_lk("R5 rw write", 40'h00_0040_1008, 1, 0, 40'h00_0078_0008);
  endtask

  task automatic t_purge();
    do_fill(40'h00_0030_0000, 40'h00_0011_0000, 2'd0, 8'd1, 0, 1);
    do_fill(40'h00_0030_1000, 40'h00_0012_0000, 2'd0, 8'd1, 0, 1);
    do_purge(40'h00_0030_0000, 8'd1);
    check_lk("R6 purged", 40'h00_0030_0004, 0, 1, 0);
    check_lk("R6 kept", 40'h00_0030_1004, 0, 0, 40'h00_0012_0004);
    do_purge(40'h00_0030_1000, 8'd9);
    check_lk("R6 pid mismatch", 40'h00_0030_1004, 0, 0, 40'h00_0012_0004);
  endtask

  task automatic t_overlap();
    do_flush();
    do_fill(40'h00_0007_7000, 40'h00_00AA_A000, 2'd0, 8'd1, 0, 1);
    do_fill(40'h00_0000_0000, 40'h0B_0000_0000, 2'd1, 8'd1, 0, 1);
    check_lk("R9 low idx", 40'h00_0007_7123, 0, 0, 40'h00_00AA_A123);
    check_lk("R9 other", 40'h00_0007_8004, 0, 0, 40'h0B_0007_8004);
  endtask

  task automatic t_same_cycle();
    do_fill(40'h00_0050_0000, 40'h00_0090_0000, 2'd0, 8'd1, 0, 1);
    @(negedge clk);
    req_valid = 1; req_vaddr = 40'h00_0050_0010;
    purge_valid = 1; purge_vaddr = 40'h00_0050_0000; purge_pid = 8'd1;
    @(negedge clk);
    req_valid = 0; purge_valid = 0;
    judge("R10 lookup+purge", 0, 40'h00_0090_0010);
    check_lk("R10 after purge", 40'h00_0050_0010, 0, 1, 0);
    @(negedge clk);
    req_valid = 1; req_vaddr = 40'h00_0051_0020;
    drive_fill(40'h00_0051_0000, 40'h00_0091_0000, 2'd0, 8'd1, 0, 1);
    @(negedge clk);
    req_valid = 0; fill_valid = 0;
    judge("R10 lookup+fill", 1, 0);
    check_lk("R10 retry", 40'h00_0051_0020, 0, 0, 40'h00_0091_0020);
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush_all = 1;
    drive_fill(40'h00_0060_0000, 40'h00_00C0_0000, 2'd0, 8'd1, 0, 1);
    @(negedge clk);
    flush_all = 0; fill_valid = 0;
    check_lk("R7 flushed", 40'h00_0051_0020, 0, 1, 0);
    check_lk("R7 flushed 2M", 40'h00_0007_8004, 0, 1, 0);
    check_lk("R12 fill dropped", 40'h00_0060_0000, 0, 1, 0);
  endtask

  task automatic t_replace();
    do_flush();
    for (int i = 0; i < 16; i++)
      do_fill(40'(i) << 12, (40'(i) + 40'h100) << 12, 2'd0, 8'd1, 0, 1);
    check_lk("R8 full e15", 40'h00_0000_F004, 0, 0, 40'h00_0010_F004);
    do_fill(40'h00_0005_0000, 40'h00_0020_0000, 2'd0, 8'd1, 0, 1);
    check_lk("R8 victim0 gone", 40'h00_0000_0004, 0, 1, 0);
    check_lk("R8 new in", 40'h00_0005_0004, 0, 0, 40'h00_0020_0004);
    check_lk("R8 e1 kept", 40'h00_0000_1004, 0, 0, 40'h00_0010_1004);
    do_fill(40'h00_0005_1000, 40'h00_0021_0000, 2'd0, 8'd1, 0, 1);
    check_lk("R8 victim1 gone", 40'h00_0000_1004, 0, 1, 0);
    check_lk("R8 e2 kept", 40'h00_0000_2004, 0, 0, 40'h00_0010_2004);
    do_purge(40'h00_0000_5000, 8'd1);
    do_fill(40'h00_0005_2000, 40'h00_0022_0000, 2'd0, 8'd1, 0, 1);
    check_lk("R8 free first", 40'h00_0005_2004, 0, 0, 40'h00_0022_0004);
    check_lk("R8 ptr held", 40'h00_0000_2004, 0, 0, 40'h00_0010_2004);
    do_fill(40'h00_0005_3000, 40'h00_0023_0000, 2'd0, 8'd1, 0, 1);
    check_lk("R8 victim2 gone", 40'h00_0000_2004, 0, 1, 0);
    check_lk("R8 e3 kept", 40'h00_0000_3004, 0, 0, 40'h00_0010_3004);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pid();
    t_super();
    t_perm();
    t_purge();
    t_overlap();
    t_same_cycle();
    t_flush();
    t_replace();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule